// File: doc/BRIEF.md
# Configurable Bidirectional I/O Port

This block is an 8-bit I/O port that a processor core reaches through three byte locations on a small register bus. One location holds a per-bit setup register. One holds a per-bit output value register. The third is a read-only view of the pad levels, taken through a two-flop synchroniser. Each bit's setup bit and value bit together pick one of four pad behaviours: floating input, input with weak pull-up, driven low, or driven high. The block turns that pair into per-pin output enable, output level and pull-up enable signals for the pad ring.

A build parameter selects one of three flavours.

- **General:** all eight bits are configurable.
- **Special:** bits 6 and 7 of the value location are command strobes, not storage. Writing a 1 to bit 7 asks the chip to halt, and writing a 1 to bit 6 asks it to idle. Setup bits 6 and 7 act as two control flags: an alternate serial clock phase and a clock start-up delay after halt. Pins 6 and 7 stay floating inputs.
- **Output-only:** every pin is always driven, and the value register presets to all ones under reset.

Reads are registered, so the byte for an address presented on one cycle appears on the read bus after the next clock edge.

Top module: `cfg_io_port`

## Requirements
- R1: While reset is applied (synchronous, active high), the setup and value registers clear. In the general and special flavours every pin is then a floating input: output enable 0, pull-up 0, output level 0. Reading setup or value returns 0.
- R2: For each configurable bit with setup bit s and value bit v, the pad signals are decoded as follows (output level is 0 whenever the pin is not driven):

  | s | v | Output enable | Output level | Pull-up |
  |---|---|---|---|---|
  | 0 | 0 | 0 | 0 | 0 |
  | 0 | 1 | 0 | 0 | 1 |
  | 1 | 0 | 1 | 0 | 0 |
  | 1 | 1 | 1 | 1 | 0 |

- R3: `bus_sel` decodes as 0 = setup, 1 = value, 2 = pin levels, 3 = unused. Reading sel 3 returns 0. Writes to sel 2 or 3 change no register and no pad signal.
- R4: A write with `bus_we` high takes effect at that clock edge. A read of setup or value returns the last byte written, and appears on `bus_rdata` after the edge at which `bus_sel` was sampled.
- R5: A read of sel 2 returns the pad inputs through two synchronising flops. A pad change that is held steady appears on `bus_rdata` at the third clock edge after the change, and not at the second.
- R6: In the special flavour, a value write with bit 7 set raises `halt_req` for exactly the one cycle after the write edge. Bit 6 does the same for `idle_req`. Both stay low otherwise, and in the other flavours.
- R7: In the special flavour, value bits 6 and 7 always read as 0, and pins 6 and 7 keep output enable, output level and pull-up at 0 for any register contents.
- R8: In the special flavour, setup bit 6 drives `alt_clk_phase` and setup bit 7 drives `halt_start_delay`. Both bits read back as written.
- R9: In the output-only flavour, reset presets the value register to all ones. Output enable is always all ones, pull-up always 0, and the output level equals the value register. Setup writes are ignored, and setup reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Register select: 0 setup, 1 value, 2 pin levels, 3 unused |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output level |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| halt_req | output | 1 | One-cycle halt request (special flavour) |
| idle_req | output | 1 | One-cycle idle request (special flavour) |
| alt_clk_phase | output | 1 | Alternate serial clock phase flag (special flavour) |
| halt_start_delay | output | 1 | Start-up delay after halt enable (special flavour) |

## Verification
The hardest case to reach is the interaction of the strobe bits with stored state in the special flavour. A value write must fire a request pulse, leave bits 6 and 7 reading zero, and keep pins 6 and 7 floating, all while the lower six bits take every mode pair. The stimulus reaches this by sweeping all 256 setup bytes against four value patterns that set and clear both strobe bits. The same shared bus drives all three flavours, so each flavour's pad decode, readback and request pulse is compared on every vector. Pin latency is pinned down by checking the read bus both one edge before and at the edge where a new pad level must appear.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  typedef enum logic [1:0] {
    KIND_GENERAL = 2'd0,
    KIND_SPECIAL = 2'd1,
    KIND_OUTPUT  = 2'd2
  } port_kind_e;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_DAT  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // bit positions of the strobe/flag bits in the special flavour
  localparam int HALT_BIT = 7;
  localparam int IDLE_BIT = 6;
endpackage

// File: rtl/cfgport_regs.sv
module cfgport_regs
  import cfgport_pkg::*;
#(
  parameter int         W    = 8,
  parameter port_kind_e KIND = KIND_GENERAL
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [1:0]   sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cfg_q,
  output logic [W-1:0] dat_q,
  output logic         halt_req,
  output logic         idle_req
);
  localparam logic [W-1:0] STROBE_BITS = (W'(1) << HALT_BIT) | (W'(1) << IDLE_BIT);
  localparam logic [W-1:0] DAT_KEEP    = (KIND == KIND_SPECIAL) ? ~STROBE_BITS : {W{1'b1}};
  localparam logic [W-1:0] DAT_RESET   = (KIND == KIND_OUTPUT) ? {W{1'b1}} : {W{1'b0}};

  logic wr_cfg, wr_dat;
  assign wr_cfg = we && (sel == SEL_CFG);
  assign wr_dat = we && (sel == SEL_DAT);

  generate
    if (KIND == KIND_OUTPUT) begin : g_no_cfg
      assign cfg_q = '0;
    end else begin : g_cfg
      always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (wr_cfg) cfg_q <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         dat_q <= DAT_RESET;
    else if (wr_dat) dat_q <= wdata & DAT_KEEP;
  end

  generate
    if (KIND == KIND_SPECIAL) begin : g_strobe
      always_ff @(posedge clk) begin
        if (rst) begin
          halt_req <= 1'b0;
          idle_req <= 1'b0;
        end else begin
          halt_req <= wr_dat && wdata[HALT_BIT];
          idle_req <= wr_dat && wdata[IDLE_BIT];
        end
      end
    end else begin : g_no_strobe
      assign halt_req = 1'b0;
      assign idle_req = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cfgport_padmode.sv
module cfgport_padmode
  import cfgport_pkg::*;
#(
  parameter int         W    = 8,
  parameter port_kind_e KIND = KIND_GENERAL
) (
  input  logic [W-1:0] cfg_q,
  input  logic [W-1:0] dat_q,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (KIND == KIND_OUTPUT) begin : g_drive
        assign pad_oe[i]  = 1'b1;
        assign pad_out[i] = dat_q[i];
        assign pad_pu[i]  = 1'b0;
      end else if (KIND == KIND_SPECIAL && (i == HALT_BIT || i == IDLE_BIT)) begin : g_fixed_in
        assign pad_oe[i]  = 1'b0;
        assign pad_out[i] = 1'b0;
        assign pad_pu[i]  = 1'b0;
      end else begin : g_mode
        // setup bit picks drive vs. input; value bit picks level or pull-up
        assign pad_oe[i]  = cfg_q[i];
        assign pad_out[i] = cfg_q[i] & dat_q[i];
        assign pad_pu[i]  = ~cfg_q[i] & dat_q[i];
      end
    end
  endgenerate
endmodule

// File: rtl/cfgport_sync.sv
module cfgport_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst)         chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
  import cfgport_pkg::*;
#(
  parameter int         W           = 8,
  parameter port_kind_e KIND        = KIND_GENERAL,
  parameter int         SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   bus_sel,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu,
  output logic         halt_req,
  output logic         idle_req,
  output logic         alt_clk_phase,
  output logic         halt_start_delay
);
  logic [W-1:0] cfg_q, dat_q, pin_q;

  cfgport_regs #(.W(W), .KIND(KIND)) regs_i (
    .clk(clk), .rst(rst), .we(bus_we), .sel(bus_sel), .wdata(bus_wdata),
    .cfg_q(cfg_q), .dat_q(dat_q), .halt_req(halt_req), .idle_req(idle_req)
  );

  cfgport_padmode #(.W(W), .KIND(KIND)) pad_i (
    .cfg_q(cfg_q), .dat_q(dat_q),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  cfgport_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_q)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_sel)
        SEL_CFG: bus_rdata <= cfg_q;
        SEL_DAT: bus_rdata <= dat_q;
        SEL_PIN: bus_rdata <= pin_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  generate
    if (KIND == KIND_SPECIAL) begin : g_flags
      assign alt_clk_phase    = cfg_q[IDLE_BIT];
      assign halt_start_delay = cfg_q[HALT_BIT];
    end else begin : g_no_flags
      assign alt_clk_phase    = 1'b0;
      assign halt_start_delay = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk
  import cfgport_pkg::*;
#(
  parameter int         W    = 8,
  parameter port_kind_e KIND = KIND_GENERAL
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   bus_sel,
  input logic         bus_we,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_pu,
  input logic         halt_req
);
  localparam logic [W-1:0] STROBE_BITS = (W'(1) << HALT_BIT) | (W'(1) << IDLE_BIT);
  localparam logic [W-1:0] OE_KEEP     = (KIND == KIND_SPECIAL) ? ~STROBE_BITS : {W{1'b1}};
  localparam logic [W-1:0] RST_OE      = (KIND == KIND_OUTPUT) ? {W{1'b1}} : {W{1'b0}};

  assert_reset_pads_R1: assert property (@(posedge clk)
    rst |=> (pad_pu == '0) && (pad_oe == RST_OE));

  assert_cfg_write_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_sel == SEL_CFG && KIND != KIND_OUTPUT) |=> (pad_oe == ($past(bus_wdata) & OE_KEEP)));

  assert_halt_cause_R6: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> $past(bus_we && bus_sel == SEL_DAT && bus_wdata[HALT_BIT]));

  assert_halt_fires_R6: assert property (@(posedge clk) disable iff (rst)
    (KIND == KIND_SPECIAL && bus_we && bus_sel == SEL_DAT && bus_wdata[HALT_BIT]) |=> halt_req);

  assert_strobe_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (KIND == KIND_SPECIAL && $past(bus_sel) == SEL_DAT) |-> (bus_rdata[HALT_BIT] == 1'b0 && bus_rdata[IDLE_BIT] == 1'b0));

  assert_always_driven_R9: assert property (@(posedge clk) disable iff (rst)
    (KIND == KIND_OUTPUT) |-> (pad_oe == {W{1'b1}} && pad_pu == '0));
endmodule

bind cfg_io_port cfgport_chk #(.W(W), .KIND(KIND)) chk_i (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pad_oe(pad_oe), .pad_pu(pad_pu), .halt_req(halt_req)
);

// File: tb/cfg_io_port_tb.sv
`timescale 1ns/1ps
module cfg_io_port_tb_top;
  import cfgport_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] pad_in = 8'h00;

  logic [7:0] g_rd, g_oe, g_out, g_pu;
  logic       g_halt, g_idle, g_alt, g_dly;
  logic [7:0] s_rd, s_oe, s_out, s_pu;
  logic       s_halt, s_idle, s_alt, s_dly;
  logic [7:0] o_rd, o_oe, o_out, o_pu;
  logic       o_halt, o_idle, o_alt, o_dly;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_io_port #(.KIND(KIND_GENERAL)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(g_rd), .pad_in(pad_in), .pad_oe(g_oe), .pad_out(g_out), .pad_pu(g_pu),
    .halt_req(g_halt), .idle_req(g_idle), .alt_clk_phase(g_alt), .halt_start_delay(g_dly));

  cfg_io_port #(.KIND(KIND_SPECIAL)) dut_sp_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(s_rd), .pad_in(pad_in), .pad_oe(s_oe), .pad_out(s_out), .pad_pu(s_pu),
    .halt_req(s_halt), .idle_req(s_idle), .alt_clk_phase(s_alt), .halt_start_delay(s_dly));

  cfg_io_port #(.KIND(KIND_OUTPUT)) dut_out_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(o_rd), .pad_in(pad_in), .pad_oe(o_oe), .pad_out(o_out), .pad_pu(o_pu),
    .halt_req(o_halt), .idle_req(o_idle), .alt_clk_phase(o_alt), .halt_start_delay(o_dly));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    bus_sel = a; bus_we = 1'b0;
    @(negedge clk);
  endtask

  // expected pad signals for the mode-pair decode (R2)
  task automatic check_pads(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] sm;
    sm = 8'h3F;
    chk("R2 general oe",  {24'd0, g_oe},  {24'd0, c});
    chk("R2 general out", {24'd0, g_out}, {24'd0, c & d});
    chk("R2 general pu",  {24'd0, g_pu},  {24'd0, ~c & d});
    chk("R7 special oe/out/pu", {s_oe, s_out, s_pu}, {c & sm, c & d & sm, ~c & d & sm});
    chk("R9 output-only oe/out/pu", {o_oe, o_out, o_pu}, {8'hFF, d, 8'h00});
    chk("R8 special flags", {30'd0, s_dly, s_alt}, {30'd0, c[7], c[6]});
  endtask

  task automatic check_reset_state();
    chk("R1 general pads", {g_oe, g_out, g_pu}, 24'h0);
    chk("R1 special pads", {s_oe, s_out, s_pu}, 24'h0);
    chk("R9 output-only preset", {o_oe, o_out, o_pu}, {8'hFF, 8'hFF, 8'h00});
    rd(SEL_CFG);
    chk("R1 cfg reads zero", {g_rd, s_rd, o_rd}, 24'h0);
    rd(SEL_DAT);
    chk("R1 data reads zero", {8'd0, g_rd, s_rd}, 24'h0);
    chk("R9 data reads ones", {24'd0, o_rd}, {24'd0, 8'hFF});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      nvec++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [4];
    logic [7:0] prev;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reset_state();

    // exhaustive setup byte sweep against four value patterns
    for (int c = 0; c < 256; c++) begin
      for (int p = 0; p < 4; p++) begin
        wr(SEL_CFG, c[7:0]);
        chk("R4 cfg write effect next edge", {24'd0, g_oe}, {24'd0, c[7:0]});
        wr(SEL_DAT, pats[p]);
        chk("R6 halt pulse", {31'd0, s_halt}, {31'd0, pats[p][7]});
        chk("R6 idle pulse", {31'd0, s_idle}, {31'd0, pats[p][6]});
        chk("R6 no pulse other flavours", {30'd0, g_halt | o_halt, g_idle | o_idle}, 32'd0);
        check_pads(c[7:0], pats[p]);
        rd(SEL_CFG);
        chk("R6 pulse one cycle", {30'd0, s_halt, s_idle}, 32'd0);
        chk("R4 cfg readback", {g_rd, s_rd, o_rd}, {c[7:0], c[7:0], 8'h00});
        rd(SEL_DAT);
        chk("R4 data readback", {g_rd, s_rd, o_rd}, {pats[p], pats[p] & 8'h3F, pats[p]});
      end
    end

    // writes to pin and unused locations are ignored
    wr(SEL_CFG, 8'h3C);
    wr(SEL_DAT, 8'h96);
    wr(SEL_PIN, 8'hFF);
    wr(SEL_NONE, 8'h00);
    check_pads(8'h3C, 8'h96);
    rd(SEL_CFG);
    chk("R3 cfg untouched", {24'd0, g_rd}, {24'd0, 8'h3C});
    rd(SEL_DAT);
    chk("R3 data untouched", {24'd0, g_rd}, {24'd0, 8'h96});
    rd(SEL_NONE);
    chk("R3 unused reads zero", {g_rd, s_rd, o_rd}, 24'h0);

    // pin sweep: value must appear at the third edge, not the second
    @(negedge clk);
    bus_sel = SEL_PIN;
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    prev = 8'h00;
    for (int v = 1; v < 256; v++) begin
      pad_in = v[7:0] ^ 8'h5C;
      @(negedge clk);
      @(negedge clk);
      chk("R5 pin not yet visible", {24'd0, g_rd}, {24'd0, prev});
      @(negedge clk);
      chk("R5 pin synced read", {g_rd, s_rd, o_rd}, {3{pad_in}});
      prev = pad_in;
    end

    // mid-run reset returns everything to its reset state
    wr(SEL_CFG, 8'hFF);
    wr(SEL_DAT, 8'h0F);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_reset_state();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule